// File: doc/BRIEF.md
# Stream-Gated Wall Clock Advancer

This block owns a wide wall-clock register that several audio streams share. Software or a scheduler raises a one-cycle request carrying a target time and a force flag. A normal request moves the register only once every active stream says it has gone past the target. The value it then writes is the largest of the target, every active stream's elapsed count and the current register, so the clock only moves forward and never falls behind a stream. A forced request writes the target directly and skips both the gating and the maximum.

One cycle after each request the block pulses a done flag and reports whether the register now holds exactly the requested value. If it does not, the update counts as delayed. The block also counts consecutive normal commits that leave the register where it was, and raises a stall warning once that run grows past a limit. Which streams are active, and how streams work out their own progress, are decided outside the block.

Top module: `stream_gated_wallclk`

## Requirements
- R1: A non-forced request is committed only when every stream whose active bit is 1 has its passed bit at 1. Otherwise the register keeps its value.
- R2: A committed non-forced request writes the maximum of the requested value, the elapsed count of each active stream and the current register value.
- R3: A forced request (req_force_i=1) writes req_value_i into the register whatever the stream flags and counts are.
- R4: The register never decreases as the result of a non-forced request.
- R5: done_o is 1 in the cycle after a request and 0 otherwise. In that cycle ok_o is 1 exactly when wallclk_o equals the requested value. ok_o is 0 whenever done_o is 0.
- R6: A stream whose active bit is 0 neither blocks a commit nor raises the committed value. Stream i uses bit i of the flag vectors and bits [64*i+63:64*i] of strm_elapsed_i.
- R7: Each non-forced commit that leaves the value unchanged adds one to a stall count. A non-forced commit that changes the value, or any forced commit, clears the count. Requests that are not committed leave it alone. stall_warn_o is 1 while the count is above 3.
- R8: After reset, wallclk_o is 0 and done_o, ok_o and stall_warn_o are 0.
- R9: With no request, wallclk_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle update request |
| req_force_i | input | 1 | Force flag of the request |
| req_value_i | input | 64 | Requested wall-clock value |
| strm_active_i | input | 3 | Per-stream active mask |
| strm_passed_i | input | 3 | Per-stream "has passed the target" flag |
| strm_elapsed_i | input | 192 | Per-stream absolute elapsed count, 64 bits per stream |
| wallclk_o | output | 64 | Current wall-clock register |
| done_o | output | 1 | Result valid, one cycle after a request |
| ok_o | output | 1 | Register equals the requested value |
| stall_warn_o | output | 1 | Stall run exceeds the limit |

## Verification
Every result is due exactly one clock edge after the edge that samples a request: the new wall-clock value, the done pulse, the ok flag and the updated stall warning all come from registers loaded by that single edge. The bench drives each request on a falling edge. Its reference model updates its own state for the next rising edge, and it compares all four outputs on the following falling edge, so every comparison lands in the cycle where the result is due. Idle cycles go through the same compare, which checks that nothing moves and that done and ok stay low.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
  localparam int unsigned DEF_CLK_W       = 64;
  localparam int unsigned DEF_STREAMS     = 3;
  localparam int unsigned DEF_STALL_LIMIT = 3;
endpackage

// File: rtl/wclk_stream_reduce.sv
module wclk_stream_reduce #(
  parameter int unsigned N = wclk_pkg::DEF_STREAMS,
  parameter int unsigned W = wclk_pkg::DEF_CLK_W
) (
  input  logic [W-1:0]   value_i,
  input  logic [N-1:0]   active_i,
  input  logic [N-1:0]   passed_i,
  input  logic [N*W-1:0] elapsed_i,
  output logic           all_passed_o,
  output logic [W-1:0]   max_o
);
  logic [N-1:0][W-1:0] masked;
  logic [N-1:0]        blocked;

  for (genvar g = 0; g < N; g++) begin : g_strm
    assign masked[g]  = active_i[g] ? elapsed_i[g*W +: W] : '0;
    assign blocked[g] = active_i[g] & ~passed_i[g];
  end

  assign all_passed_o = ~|blocked;

  always_comb begin
    max_o = value_i;
    for (int i = 0; i < N; i++) begin
      if (masked[i] > max_o) max_o = masked[i];
    end
  end
endmodule

// File: rtl/wclk_stall_track.sv
module wclk_stall_track #(
  parameter int unsigned LIMIT = wclk_pkg::DEF_STALL_LIMIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nf_commit_i,
  input  logic nf_same_i,
  input  logic f_commit_i,
  output logic warn_o
);
  localparam int unsigned SAT = LIMIT + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (f_commit_i) begin
      cnt_q <= '0;
    end else if (nf_commit_i) begin
      if (!nf_same_i)                cnt_q <= '0;
      else if (cnt_q != CW'(SAT))    cnt_q <= cnt_q + 1'b1;  // saturate just past limit
    end
  end

  assign warn_o = (cnt_q > CW'(LIMIT));
endmodule

// File: rtl/stream_gated_wallclk.sv
module stream_gated_wallclk #(
  parameter int unsigned N_STREAMS   = wclk_pkg::DEF_STREAMS,
  parameter int unsigned CLK_W       = wclk_pkg::DEF_CLK_W,
  parameter int unsigned STALL_LIMIT = wclk_pkg::DEF_STALL_LIMIT
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      req_force_i,
  input  logic [CLK_W-1:0]          req_value_i,
  input  logic [N_STREAMS-1:0]      strm_active_i,
  input  logic [N_STREAMS-1:0]      strm_passed_i,
  input  logic [N_STREAMS*CLK_W-1:0] strm_elapsed_i,
  output logic [CLK_W-1:0]          wallclk_o,
  output logic                      done_o,
  output logic                      ok_o,
  output logic                      stall_warn_o
);
  logic             all_passed;
  logic [CLK_W-1:0] strm_max;
  logic [CLK_W-1:0] nf_val, wc_d, wc_q;
  logic             commit, nf_commit, f_commit;
  logic             done_q, ok_q;

  wclk_stream_reduce #(.N(N_STREAMS), .W(CLK_W)) u_reduce (
    .value_i     (req_value_i),
    .active_i    (strm_active_i),
    .passed_i    (strm_passed_i),
    .elapsed_i   (strm_elapsed_i),
    .all_passed_o(all_passed),
    .max_o       (strm_max)
  );

  // forward-only: never below the current register
  assign nf_val    = (strm_max > wc_q) ? strm_max : wc_q;
  assign f_commit  = req_i & req_force_i;
  assign nf_commit = req_i & ~req_force_i & all_passed;
  assign commit    = f_commit | nf_commit;

  always_comb begin
    wc_d = wc_q;
    if (f_commit)       wc_d = req_value_i;
    else if (nf_commit) wc_d = nf_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q   <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      if (commit) wc_q <= wc_d;
      done_q <= req_i;
      ok_q   <= req_i & (wc_d == req_value_i);
    end
  end

  wclk_stall_track #(.LIMIT(STALL_LIMIT)) u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nf_commit_i(nf_commit),
    .nf_same_i  (nf_val == wc_q),
    .f_commit_i (f_commit),
    .warn_o     (stall_warn_o)
  );

  assign wallclk_o = wc_q;
  assign done_o    = done_q;
  assign ok_o      = ok_q;
endmodule

// File: rtl/wclk_checker.sv
module wclk_checker #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_i,
  input logic         req_force_i,
  input logic [W-1:0] req_value_i,
  input logic [N-1:0] strm_active_i,
  input logic [N-1:0] strm_passed_i,
  input logic [W-1:0] wallclk_o,
  input logic         done_o,
  input logic         ok_o
);
  a_r1_blocked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !req_force_i && |(strm_active_i & ~strm_passed_i) |=> $stable(wallclk_o));

  a_r3_force_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_force_i |=> wallclk_o == $past(req_value_i));

  a_r4_no_backward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !req_force_i |=> wallclk_o >= $past(wallclk_o));

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);

  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o && !ok_o);

  a_r5_ok_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ok_o == (wallclk_o == $past(req_value_i)));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(wallclk_o));
endmodule

bind stream_gated_wallclk wclk_checker #(.N(N_STREAMS), .W(CLK_W)) u_wclk_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .req_force_i  (req_force_i),
  .req_value_i  (req_value_i),
  .strm_active_i(strm_active_i),
  .strm_passed_i(strm_passed_i),
  .wallclk_o    (wallclk_o),
  .done_o       (done_o),
  .ok_o         (ok_o)
);

// File: tb/stream_gated_wallclk_bench.sv
`timescale 1ns/1ps
module stream_gated_wallclk_bench;
  localparam int N = 3;
  localparam int W = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req = 1'b0, frc = 1'b0;
  logic [W-1:0]   val = '0;
  logic [N-1:0]   act = '0, pas = '0;
  logic [N*W-1:0] ela = '0;
  logic [W-1:0]   wc;
  logic           done, ok, warn;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  logic [W-1:0] m_wc = '0;
  int           m_cnt = 0;
  bit           m_done = 0, m_ok = 0;

  always #2.5 clk = ~clk;

  stream_gated_wallclk u_stream_gated_wallclk (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_force_i(frc), .req_value_i(val),
    .strm_active_i(act), .strm_passed_i(pas), .strm_elapsed_i(ela),
    .wallclk_o(wc), .done_o(done), .ok_o(ok), .stall_warn_o(warn)
  );

  task automatic chk(input bit good, input string tag, input logic [W-1:0] act_v, input logic [W-1:0] exp_v);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(wc == m_wc, tag, wc, m_wc);
    chk(done == m_done, "R5 done", W'(done), W'(m_done));
    chk(ok == m_ok, "R5 ok", W'(ok), W'(m_ok));
    chk(warn == (m_cnt > 3), "R7 warn", W'(warn), W'(m_cnt > 3));
  endtask

  // drive one cycle (inputs already at negedge), model next state, compare at next negedge
  task automatic step(input bit r, input bit f, input logic [W-1:0] v, input logic [N-1:0] a,
                      input logic [N-1:0] p, input logic [W-1:0] e0, input logic [W-1:0] e1,
                      input logic [W-1:0] e2, input string tag);
    logic [W-1:0] e [N];
    logic [W-1:0] mx;
    bit all;
    req = r; frc = f; val = v; act = a; pas = p;
    ela = {e2, e1, e0};
    e[0] = e0; e[1] = e1; e[2] = e2;
    if (r) begin
      all = 1; mx = v;
      for (int i = 0; i < N; i++) if (a[i]) begin
        if (!p[i]) all = 0;
        if (e[i] > mx) mx = e[i];
      end
      if (f) begin
        m_wc = v; m_cnt = 0;
      end else if (all) begin
        if (m_wc > mx) mx = m_wc;
        if (mx == m_wc) m_cnt = (m_cnt < 4) ? m_cnt + 1 : 4;
        else m_cnt = 0;
        m_wc = mx;
      end
      m_done = 1; m_ok = (m_wc == v);
    end else begin
      m_done = 0; m_ok = 0;
    end
    @(posedge clk); @(negedge clk);
    req = 0;
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R8 after release");
    step(0, 0, 64'h55, '1, '0, 0, 0, 0, "R9 idle");
    // R2: all passed, stream elapsed exceeds target
    step(1, 0, 64'd100, 3'b111, 3'b111, 64'd90, 64'd150, 64'd120, "R2 max of streams");
    // R1: one active stream not passed
    step(1, 0, 64'd200, 3'b111, 3'b101, 64'd210, 64'd0, 64'd0, "R1 blocked");
    // R6: inactive stream not passed and huge elapsed ignored
    step(1, 0, 64'd300, 3'b011, 3'b011, 64'd250, 64'd260, 64'hFFFF_0000, "R6 masked");
    // R3: force backwards
    step(1, 1, 64'd40, 3'b111, 3'b000, 64'd999, 64'd999, 64'd999, "R3 force");
    // R4: non-forced target below current
    step(1, 0, 64'd10, 3'b000, 3'b000, 0, 0, 0, "R4 no backward");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
    // R7: stall run
    for (int k = 0; k < 5; k++)
      step(1, 0, 64'd40, 3'b001, 3'b001, 64'd5, 0, 0, "R7 stall run");
    step(1, 0, 64'd41, 3'b000, 3'b000, 0, 0, 0, "R7 cleared by change");
    for (int k = 0; k < 5; k++)
      step(1, 0, 64'd41, 3'b000, 3'b000, 0, 0, 0, "R7 stall again");
    step(1, 1, 64'd41, 3'b000, 3'b000, 0, 0, 0, "R7 force clears");
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] base;
      base = m_wc;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0,
           base + W'($urandom_range(0, 20)) - W'($urandom_range(0, 10)),
           N'($urandom), N'($urandom | $urandom),
           base + W'($urandom_range(0, 30)), base + W'($urandom_range(0, 30)),
           base + W'($urandom_range(0, 30)), "R2 random");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule